// File: doc/BRIEF.md
# Dual-Channel Tick Timer

This peripheral sits on a simple 32-bit register bus and turns a common tick input into two time bases. The first channel is a one-shot event timer. It counts prescaled ticks upward from zero and raises a sticky flag when its count reaches a programmed compare value. That flag can drive the single interrupt output. The second channel is a free-running 64-bit counter. Software reads it as a low word and then a buffered high word.

Each channel has its own 2-bit prescaler. Both prescaler fields sit in one control register, and the available ratios are powers of four. Channels are started through a write-one-to-set register and stopped through a separate write-one-to-clear register. Software never needs a read-modify-write to change one channel without disturbing the other.

A typical one-shot sequence is:
1. Clear the flag.
2. Load the compare value.
3. Zero the counter.
4. Start channel 1.
5. Unmask the interrupt.

Supported one-shot delays run from 4 up to 0xFFFFFFFF prescaled ticks.

Top module: `tick_timer`

## Requirements
- R1: After reset:
  - both prescale fields read 0;
  - both channels are stopped (offset 0x34 reads 0);
  - channel 1's count, compare value and flag are 0;
  - the mask bit reads 1;
  - `irq_o` is 0;
  - channel 2 holds the value of parameter `CNT2_INIT` (default 0).
- R2: The control register at offset 0x00 holds two prescale fields: bits [1:0] for channel 1 and bits [3:2] for channel 2. Field value 0 gives one count step per tick, 1 gives one per 4 ticks, and 2 or 3 give one per 16 ticks. Bits above 3 read 0. Any write to this register restarts both prescalers' tick counts.
- R3: Writing offset 0x08 with bit 0 set zeroes channel 1's count, and with bit 1 set zeroes channel 2's count. A 0 bit leaves that counter unchanged, and the register reads 0.
- R4: Writing a 1 to bit n at offset 0x34 starts channel n+1, and writing a 1 to bit n at offset 0x38 stops it. Zero bits change nothing. Offset 0x34 reads {en2, en1} in bits [1:0]. A stopped channel holds its count.
- R5: Bit 0 at offset 0x0C sets on the channel 1 count step that makes the count equal the compare value at offset 0x14. The flag then stays set while the count keeps advancing. Writing 0 to bit 0 clears it, and writing 1 has no effect.
- R6: `irq_o` is high exactly when the flag is set and mask bit 0 at offset 0x10 is 0.
- R7: Offset 0x20 reads the low 32 bits of channel 2. A read there copies the upper 32 bits into the buffer read at offset 0x24, so the buffer stays unchanged when the low word carries after that read.
- R8: The compare value at offset 0x14 reads back as written over all 32 bits. Channel 1's count reads at offset 0x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Common tick enable feeding both prescalers |
| addr_i | input | 6 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe, used for the high-word capture |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational on `addr_i` |
| irq_o | output | 1 | Channel 1 interrupt |

## Verification
The hardest case to reach is a carry from the low word into the high word between reading offset 0x20 and reading offset 0x24. Starting from zero, it would take four billion steps to get there. The bench therefore sets `CNT2_INIT` to 0xFFFFFFF0. It reads the low word a few ticks before the carry, runs across the carry, and confirms that the buffer still shows the pre-carry high word until the low word is read again. Prescaler restarts are checked by writing the control register partway through a divide period and counting the ticks to the next step.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NCH    = 2;
  localparam int unsigned PSC_W  = 2;

  // Offsets kept fixed: software drivers decode them.
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_FLAG  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_CMP   = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_CNT1  = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_CNT2L = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_CNT2H = 6'h24;
  localparam logic [ADDR_W-1:0] OFF_ENSET = 6'h34;
  localparam logic [ADDR_W-1:0] OFF_ENCLR = 6'h38;

  typedef enum logic [1:0] {
    DIV_1  = 2'd0,
    DIV_4  = 2'd1,
    DIV_16 = 2'd2,
    DIV_16B = 2'd3
  } div_sel_e;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import tick_timer_pkg::*;
#(
  parameter int unsigned CW = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [PSC_W-1:0] sel_i,
  output logic             step_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  always_comb begin
    unique case (div_sel_e'(sel_i))
      DIV_1:   lim = CW'(0);
      DIV_4:   lim = CW'(3);
      default: lim = CW'(15);
    endcase
  end

  assign step_o = tick_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= (cnt_q == lim) ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/tick_evt_chan.sv
module tick_evt_chan #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic [W-1:0] cmp_i,
  input  logic         flag_clr_i,
  output logic [W-1:0] cnt_o,
  output logic         flag_o
);
  logic [W-1:0] cnt_q;
  logic         flag_q;
  logic         adv;
  logic [W-1:0] cnt_nx;

  assign adv    = en_i && step_i && !clr_i;
  assign cnt_nx = cnt_q + W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (adv)    cnt_q <= cnt_nx;
  end

  // A hardware set wins over a software clear in the same cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       flag_q <= 1'b0;
    else if (adv && cnt_nx == cmp_i)   flag_q <= 1'b1;
    else if (flag_clr_i)               flag_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/tick_free_ctr.sv
module tick_free_ctr #(
  parameter int unsigned  LW   = 32,
  parameter logic [2*LW-1:0] INIT = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  input  logic            en_i,
  input  logic            clr_i,
  input  logic            cap_i,
  output logic [2*LW-1:0] cnt_o,
  output logic [LW-1:0]   hi_buf_o
);
  localparam int unsigned W = 2 * LW;
  logic [W-1:0]  cnt_q;
  logic [LW-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= INIT;
    else if (clr_i)           cnt_q <= '0;
    else if (en_i && step_i)  cnt_q <= cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_q <= '0;
    else if (cap_i) hi_q <= cnt_q[W-1:LW];
  end

  assign cnt_o    = cnt_q;
  assign hi_buf_o = hi_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned         PS_CW     = 4,
  parameter logic [2*DATA_W-1:0] CNT2_INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned CTRL_W = NCH * PSC_W;
  localparam int unsigned C2_W   = 2 * DATA_W;

  logic [CTRL_W-1:0] psc_q;
  logic [NCH-1:0]    en_q;
  logic [NCH-1:0]    step;
  logic [NCH-1:0]    clr_cnt;
  logic              mask_q;
  logic [DATA_W-1:0] cmp_q;
  logic [DATA_W-1:0] cnt1;
  logic              flag;
  logic [C2_W-1:0]   cnt2;
  logic [DATA_W-1:0] cnt2_hi;
  logic [DATA_W-1:0] hi_buf;

  logic psc_wr, flag_wr_clr, rd_lo;
  logic en_set_wr, en_clr_wr;

  assign psc_wr      = wr_en_i && addr_i == OFF_CTRL;
  assign flag_wr_clr = wr_en_i && addr_i == OFF_FLAG && !wdata_i[0];
  assign en_set_wr   = wr_en_i && addr_i == OFF_ENSET;
  assign en_clr_wr   = wr_en_i && addr_i == OFF_ENCLR;
  assign clr_cnt     = (wr_en_i && addr_i == OFF_CLR) ? wdata_i[NCH-1:0] : '0;
  assign rd_lo       = rd_en_i && addr_i == OFF_CNT2L;
  assign cnt2_hi     = cnt2[C2_W-1:DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q  <= '0;
      mask_q <= 1'b1;
      cmp_q  <= '0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        OFF_CTRL: psc_q  <= wdata_i[CTRL_W-1:0];
        OFF_MASK: mask_q <= wdata_i[0];
        OFF_CMP:  cmp_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= '0;
    else if (en_set_wr) en_q <= en_q | wdata_i[NCH-1:0];
    else if (en_clr_wr) en_q <= en_q & ~wdata_i[NCH-1:0];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_psc
    tick_prescaler #(.CW(PS_CW)) i_psc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .restart_i (psc_wr),
      .sel_i     (psc_q[g*PSC_W +: PSC_W]),
      .step_o    (step[g])
    );
  end

  tick_evt_chan #(.W(DATA_W)) i_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step[0]),
    .en_i       (en_q[0]),
    .clr_i      (clr_cnt[0]),
    .cmp_i      (cmp_q),
    .flag_clr_i (flag_wr_clr),
    .cnt_o      (cnt1),
    .flag_o     (flag)
  );

  tick_free_ctr #(.LW(DATA_W), .INIT(CNT2_INIT)) i_free (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step[1]),
    .en_i     (en_q[1]),
    .clr_i    (clr_cnt[1]),
    .cap_i    (rd_lo),
    .cnt_o    (cnt2),
    .hi_buf_o (hi_buf)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_CTRL:  rdata_o[CTRL_W-1:0] = psc_q;
      OFF_FLAG:  rdata_o[0] = flag;
      OFF_MASK:  rdata_o[0] = mask_q;
      OFF_CMP:   rdata_o = cmp_q;
      OFF_CNT1:  rdata_o = cnt1;
      OFF_CNT2L: rdata_o = cnt2[DATA_W-1:0];
      OFF_CNT2H: rdata_o = hi_buf;
      OFF_ENSET: rdata_o[NCH-1:0] = en_q;
      default: ;
    endcase
  end

  assign irq_o = flag && !mask_q;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          irq_o,
  input logic          flag,
  input logic          mask_q,
  input logic [1:0]    en_q,
  input logic [1:0]    clr_cnt,
  input logic [1:0]    step,
  input logic [3:0]    psc_q,
  input logic          psc_wr,
  input logic          flag_wr_clr,
  input logic          rd_lo,
  input logic [DW-1:0] cnt1,
  input logic [DW-1:0] cnt2_hi,
  input logic [DW-1:0] hi_buf
);
  // R2: outside /1 mode, two steps never come back to back
  a_r2_step_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step[0] && psc_q[1:0] != 2'd0 && !psc_wr) |=> !step[0]);

  a_r4_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q[0] && !clr_cnt[0]) |=> cnt1 == $past(cnt1));

  a_r5_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && !flag_wr_clr) |=> flag);

  a_r6_mask_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q |-> !irq_o);

  a_r6_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag);

  a_r7_hi_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo |=> hi_buf == $past(cnt2_hi));
endmodule

bind tick_timer tick_timer_chk #(.DW(32)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_o       (irq_o),
  .flag        (flag),
  .mask_q      (mask_q),
  .en_q        (en_q),
  .clr_cnt     (clr_cnt),
  .step        (step),
  .psc_q       (psc_q),
  .psc_wr      (psc_wr),
  .flag_wr_clr (flag_wr_clr),
  .rd_lo       (rd_lo),
  .cnt1        (cnt1),
  .cnt2_hi     (cnt2_hi),
  .hi_buf      (hi_buf)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] v, keep;

  always #10 clk_i = ~clk_i;

  tick_timer #(.CNT2_INIT(64'h0000_0000_FFFF_FFF0)) i_tick_timer (
    .clk_i, .rst_ni, .tick_i, .addr_i, .wr_en_i, .rd_en_i,
    .wdata_i, .rdata_o, .irq_o
  );

  // {offset, write data, expected readback}
  localparam logic [69:0] VECS [0:9] = '{
    {6'h00, 32'h0000_000F, 32'h0000_000F},   // R2
    {6'h00, 32'h0000_0006, 32'h0000_0006},   // R2
    {6'h00, 32'hFFFF_FFF0, 32'h0000_0000},   // R2 upper bits
    {6'h10, 32'h0000_0000, 32'h0000_0000},   // R6
    {6'h10, 32'h0000_0001, 32'h0000_0001},   // R6
    {6'h14, 32'hFFFF_FFFF, 32'hFFFF_FFFF},   // R8
    {6'h14, 32'hA5A5_5A5A, 32'hA5A5_5A5A},   // R8
    {6'h08, 32'h0000_0000, 32'h0000_0000},   // R3
    {6'h34, 32'h0000_0000, 32'h0000_0000},   // R4
    {6'h38, 32'h0000_0003, 32'h0000_0000}    // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    #2 d = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i);
    tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(6'h00, v); chk("R1 ctrl", v, 32'h0);
    rd(6'h10, v); chk("R1 mask", v, 32'h1);
    rd(6'h0C, v); chk("R1 flag", v, 32'h0);
    rd(6'h18, v); chk("R1 cnt1", v, 32'h0);
    rd(6'h14, v); chk("R1 cmp", v, 32'h0);
    rd(6'h34, v); chk("R1 enables", v, 32'h0);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
    rd(6'h20, v); chk("R1 cnt2 low", v, 32'hFFFF_FFF0);
    rd(6'h24, v); chk("R1 cnt2 high", v, 32'h0);

    // register vectors
    for (int i = 0; i < 10; i++) begin
      wr(VECS[i][69:64], VECS[i][63:32]);
      rd(VECS[i][69:64], v);
      chk($sformatf("vector %0d (R2 R3 R4 R6 R8)", i), v, VECS[i][31:0]);
    end

    // R2 prescale ratios on channel 1
    wr(6'h14, 32'hFFFF_FFFF);
    wr(6'h00, 32'h1); wr(6'h08, 32'h1); wr(6'h34, 32'h1);
    ticks(8);  rd(6'h18, v); chk("R2 div4", v, 32'd2);
    wr(6'h00, 32'h2); wr(6'h08, 32'h1);
    ticks(32); rd(6'h18, v); chk("R2 div16", v, 32'd2);
    wr(6'h00, 32'h3); wr(6'h08, 32'h1);
    ticks(32); rd(6'h18, v); chk("R2 field3 div16", v, 32'd2);
    wr(6'h00, 32'h1); wr(6'h08, 32'h1);
    ticks(3);  rd(6'h18, v); chk("R2 partial", v, 32'd0);
    wr(6'h00, 32'h1);
    ticks(3);  rd(6'h18, v); chk("R2 restart", v, 32'd0);
    ticks(1);  rd(6'h18, v); chk("R2 after restart", v, 32'd1);
    wr(6'h00, 32'h0); wr(6'h08, 32'h1);
    ticks(7);  rd(6'h18, v); chk("R2 div1", v, 32'd7);

    // R4 enable set/clear and hold
    wr(6'h38, 32'h0);
    ticks(2);  rd(6'h18, v); chk("R4 clear-zero no effect", v, 32'd9);
    wr(6'h38, 32'h1);
    rd(6'h34, v); chk("R4 stopped", v, 32'h0);
    ticks(5);  rd(6'h18, v); chk("R4 hold", v, 32'd9);
    wr(6'h34, 32'h0);
    ticks(3);  rd(6'h18, v); chk("R4 set-zero no effect", v, 32'd9);

    // R5/R6 one-shot flag and interrupt
    wr(6'h0C, 32'h0); wr(6'h14, 32'd5); wr(6'h08, 32'h1);
    wr(6'h34, 32'h1); wr(6'h10, 32'h0);
    ticks(4);
    rd(6'h0C, v); chk("R5 flag before compare", v, 32'h0);
    chk("R6 irq low before", {31'h0, irq_o}, 32'h0);
    ticks(1);
    rd(6'h0C, v); chk("R5 flag at compare", v, 32'h1);
    chk("R6 irq raised", {31'h0, irq_o}, 32'h1);
    ticks(2);
    rd(6'h18, v); chk("R5 count continues", v, 32'd7);
    rd(6'h0C, v); chk("R5 flag sticky", v, 32'h1);
    wr(6'h0C, 32'h1);
    rd(6'h0C, v); chk("R5 write one no effect", v, 32'h1);
    wr(6'h10, 32'h1);
    chk("R6 masked", {31'h0, irq_o}, 32'h0);
    wr(6'h10, 32'h0);
    chk("R6 unmasked", {31'h0, irq_o}, 32'h1);
    wr(6'h0C, 32'h0);
    rd(6'h0C, v); chk("R5 flag cleared", v, 32'h0);
    chk("R6 irq cleared", {31'h0, irq_o}, 32'h0);

    // R7 high-word buffer across a carry
    wr(6'h38, 32'h1);
    wr(6'h00, 32'h0); wr(6'h34, 32'h2);
    ticks(8);
    rd(6'h20, v); chk("R7 low before carry", v, 32'hFFFF_FFF8);
    ticks(20);
    rd(6'h24, v); chk("R7 buffer unchanged by carry", v, 32'h0);
    rd(6'h20, v); chk("R7 low after carry", v, 32'h0000_000C);
    rd(6'h24, v); chk("R7 buffer recaptured", v, 32'h1);

    // R3 clear of channel 2 only
    rd(6'h18, keep);
    wr(6'h08, 32'h2);
    rd(6'h20, v); chk("R3 cnt2 low zeroed", v, 32'h0);
    rd(6'h24, v); chk("R3 cnt2 high zeroed", v, 32'h0);
    rd(6'h18, v); chk("R3 cnt1 untouched", v, keep);

    finish_run();
  end
endmodule